// File: doc/BRIEF.md
# Shared Cross-Correlation Response Compactor

This block compacts the responses of a circuit under test during built-in self-test. On every clock where the strobe is high, it takes one full response vector, with one bit per primary output. It correlates each output with its upper neighbour in the same vector, using the two rows of a 2x2 Hadamard matrix.

The first row gives a sum tone: the two bits of the pair added together. The second row gives a difference tone: the lower bit minus the upper bit. The contributions of all pairs are reduced by combinational logic in the same cycle. Each total is then folded into one of two shared counters that use end-around carry. There is no per-output register and no record of earlier vectors. The stored state is therefore only the two counters, whatever the output count.

Software or a test controller resets the block and streams the vectors. After the last vector it reads both counters as the signature.

Top module: `shared_xcorr_compactor`

## Requirements
- R1: An active-low asynchronous reset `rst_ni` clears both `add_sig_o` and `sub_sig_o` to zero at once, and they stay zero while reset is held.
- R2: Pair i is formed from bits i and i+1 of `resp_i`, for i = 0 to N_OUT-2. The sum tone of the pair is bit i plus bit i+1. The sum tones of all pairs in one vector are added to `add_sig_o`.
- R3: The difference tone of pair i is bit i minus bit i+1, giving -1, 0 or +1. The signed total over all pairs in one vector is added to `sub_sig_o`.
- R4: Both counters are CNT_W bits wide and count modulo M = 2^CNT_W - 1, using end-around carry. Each output always equals its running total modulo M, in the range 0 to M-1, so the all-ones code never appears.
- R5: A vector sampled with `valid_i` high at a rising clock edge is reflected in both outputs right after that same edge. Both counters update together.
- R6: While `valid_i` is low, neither output changes, whatever `resp_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Vector strobe; `resp_i` is taken when high |
| resp_i | input | N_OUT | Response vector, one bit per primary output |
| add_sig_o | output | CNT_W | Sum-tone counter (signature half) |
| sub_sig_o | output | CNT_W | Difference-tone counter (signature half) |

## Verification
A wrong fold or a wrong pairing in the reducer changes the counter value on the first vector that exercises it. The bench compares both outputs after every accepted vector, so such a fault appears within one cycle. A counter that holds the all-ones code, or that moves while the strobe is low, appears at the ports on the very next edge. The full sweep over all vectors of the default width, plus a random stretch with the strobe toggling, makes every pair pattern and every counter residue occur.

// File: rtl/sxc_pkg.sv
package sxc_pkg;

  // Ones' complement reduction modulo (2^w - 1), canonical (never all ones).
  function automatic logic [31:0] eac_reduce(input logic [31:0] v, input int unsigned w);
    logic [31:0] m;
    logic [31:0] acc;
    m   = (32'd1 << w) - 32'd1;
    acc = v;
    for (int k = 0; k < 32; k++) begin
      acc = (acc & m) + (acc >> w);
    end
    if (acc == m) acc = 32'd0;
    return acc;
  endfunction

endpackage

// File: rtl/pair_tone_unit.sv
module pair_tone_unit #(
  parameter int unsigned N_OUT = 8,
  localparam int unsigned NP   = N_OUT - 1
) (
  input  logic [N_OUT-1:0] resp_i,
  output logic [NP-1:0]    sum_lo_o,
  output logic [NP-1:0]    sum_hi_o,
  output logic [NP-1:0]    pos_o,
  output logic [NP-1:0]    neg_o
);

  for (genvar i = 0; i < NP; i++) begin : g_pair
    assign sum_lo_o[i] = resp_i[i];
    assign sum_hi_o[i] = resp_i[i+1];
    assign pos_o[i]    = resp_i[i] & ~resp_i[i+1];
    assign neg_o[i]    = ~resp_i[i] & resp_i[i+1];
  end

endmodule

// File: rtl/tone_reducer.sv
module tone_reducer
  import sxc_pkg::*;
#(
  parameter int unsigned N_OUT = 8,
  parameter int unsigned CNT_W = 2,
  localparam int unsigned NP   = N_OUT - 1,
  localparam logic [31:0] MOD  = (32'd1 << CNT_W) - 32'd1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NP-1:0]    sum_lo_i,
  input  logic [NP-1:0]    sum_hi_i,
  input  logic [NP-1:0]    pos_i,
  input  logic [NP-1:0]    neg_i,
  output logic [CNT_W-1:0] add_res_o,
  output logic [CNT_W-1:0] sub_res_o
);

  logic [31:0] add_total, pos_cnt, neg_cnt;
  logic [31:0] add_red, pos_red, neg_red, sub_red;

  always_comb begin
    add_total = '0;
    pos_cnt   = '0;
    neg_cnt   = '0;
    for (int i = 0; i < NP; i++) begin
      add_total = add_total + {31'd0, sum_lo_i[i]} + {31'd0, sum_hi_i[i]};
      pos_cnt   = pos_cnt + {31'd0, pos_i[i]};
      neg_cnt   = neg_cnt + {31'd0, neg_i[i]};
    end
  end

  always_comb begin
    add_red = eac_reduce(add_total, CNT_W);
    pos_red = eac_reduce(pos_cnt, CNT_W);
    neg_red = eac_reduce(neg_cnt, CNT_W);
    // minus neg_red via ones' complement: MOD - neg_red
    sub_red = eac_reduce(pos_red + (MOD - neg_red), CNT_W);
  end

  assign add_res_o = add_red[CNT_W-1:0];
  assign sub_res_o = sub_red[CNT_W-1:0];

  a_r3_pair_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_cnt + neg_cnt) <= NP);
  a_r2_add_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_total >= (pos_cnt + neg_cnt));

endmodule

// File: rtl/eac_counter.sv
module eac_counter
  import sxc_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      nxt_w;

  always_comb nxt_w = eac_reduce({{(32-CNT_W){1'b0}}, cnt_q} + {{(32-CNT_W){1'b0}}, inc_i}, CNT_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= nxt_w[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

  a_r1_reset_zero: assert property (@(posedge clk_i) !rst_ni |-> cnt_q == '0);
  a_r4_no_neg_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != {CNT_W{1'b1}});
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  a_r5_zero_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && inc_i == '0) |=> $stable(cnt_q));

endmodule

// File: rtl/shared_xcorr_compactor.sv
module shared_xcorr_compactor #(
  parameter int unsigned N_OUT = 8,
  parameter int unsigned CNT_W = 2,
  localparam int unsigned NP   = N_OUT - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [N_OUT-1:0] resp_i,
  output logic [CNT_W-1:0] add_sig_o,
  output logic [CNT_W-1:0] sub_sig_o
);

  logic [NP-1:0]    sum_lo, sum_hi, pos, neg;
  logic [CNT_W-1:0] add_res, sub_res;

  pair_tone_unit #(.N_OUT(N_OUT)) u_pairs (
    .resp_i  (resp_i),
    .sum_lo_o(sum_lo),
    .sum_hi_o(sum_hi),
    .pos_o   (pos),
    .neg_o   (neg)
  );

  tone_reducer #(.N_OUT(N_OUT), .CNT_W(CNT_W)) u_reduce (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sum_lo_i (sum_lo),
    .sum_hi_i (sum_hi),
    .pos_i    (pos),
    .neg_i    (neg),
    .add_res_o(add_res),
    .sub_res_o(sub_res)
  );

  eac_counter #(.CNT_W(CNT_W)) u_add_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .inc_i (add_res),
    .cnt_o (add_sig_o)
  );

  eac_counter #(.CNT_W(CNT_W)) u_sub_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .inc_i (sub_res),
    .cnt_o (sub_sig_o)
  );

  a_r5_joint_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i) |=> ($stable(add_sig_o) && $stable(sub_sig_o)));

endmodule

// File: tb/tb_shared_xcorr_compactor.sv
module tb_shared_xcorr_compactor;
  localparam int CLK_PERIOD = 10;
  localparam int N_OUT = 8;
  localparam int CNT_W = 2;
  localparam int M = (1 << CNT_W) - 1;

  logic clk = 0;
  logic rst_ni = 0;
  logic valid_i = 0;
  logic [N_OUT-1:0] resp_i = '0;
  logic [CNT_W-1:0] add_sig_o, sub_sig_o;

  int errors = 0;
  int checks = 0;
  int m_add = 0;
  int m_sub = 0;
  bit done = 0;

  shared_xcorr_compactor #(.N_OUT(N_OUT), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .resp_i(resp_i),
    .add_sig_o(add_sig_o), .sub_sig_o(sub_sig_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tone_add(input logic [N_OUT-1:0] v);
    int s = 0;
    for (int i = 0; i < N_OUT-1; i++) s += int'(v[i]) + int'(v[i+1]);
    return s;
  endfunction

  function automatic int tone_sub(input logic [N_OUT-1:0] v);
    int s = 0;
    for (int i = 0; i < N_OUT-1; i++) s += int'(v[i]) - int'(v[i+1]);
    return s;
  endfunction

  // drive at negedge, sample at following negedge (one register after posedge)
  task automatic step(input logic v, input logic [N_OUT-1:0] r, input string tag_a, input string tag_s);
    valid_i = v;
    resp_i  = r;
    @(negedge clk);
    if (v) begin
      m_add = (m_add + tone_add(r)) % M;
      m_sub = (((m_sub + tone_sub(r)) % M) + M) % M;
    end
    chk(tag_a, int'(add_sig_o), m_add);
    chk(tag_s, int'(sub_sig_o), m_sub);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk("R1 reset add", int'(add_sig_o), 0);
    chk("R1 reset sub", int'(sub_sig_o), 0);
    @(negedge clk);
    rst_ni = 1;
    // R6: strobe low, busy vector
    for (int k = 0; k < 4; k++) step(1'b0, 8'hA5 ^ 8'(k*37), "R6 hold add", "R6 hold sub");
    // R5: single vector seen right after its edge (pair0 pos: add+1, sub+1)
    step(1'b1, 8'h01, "R5 add", "R5 sub");
    // R2: all ones, every pair adds 2
    step(1'b1, 8'hFF, "R2 all-ones add", "R3 all-ones sub");
    // R3: alternating patterns
    step(1'b1, 8'h55, "R2 alt add", "R3 alt 55 sub");
    step(1'b1, 8'hAA, "R2 alt add", "R3 alt AA sub");
    step(1'b1, 8'h80, "R2 top add", "R3 top-only sub");
    // R4: exhaustive sweep, residues stay in 0..M-1
    for (int v = 0; v < 256; v++) begin
      step(1'b1, 8'(v), "R2 sweep add", "R3 sweep sub");
      checks++;
      if (int'(add_sig_o) >= M || int'(sub_sig_o) >= M) begin
        errors++;
        $display("FAIL R4 range: actual=%0d/%0d expected=<%0d", add_sig_o, sub_sig_o, M);
      end
    end
    // R6 with random data while strobe low, then mixed random
    for (int k = 0; k < 600; k++) begin
      logic vv;
      vv = ($urandom_range(0, 2) != 0);
      step(vv, 8'($urandom), vv ? "R2 rand add" : "R6 rand hold add",
                             vv ? "R3 rand sub" : "R6 rand hold sub");
    end
    // R1: async reset mid-cycle, outputs clear without a clock edge
    step(1'b1, 8'h01, "R5 pre-reset add", "R5 pre-reset sub");
    #(CLK_PERIOD/4);
    rst_ni = 0;
    #1;
    chk("R1 async add", int'(add_sig_o), 0);
    chk("R1 async sub", int'(sub_sig_o), 0);
    m_add = 0;
    m_sub = 0;
    @(negedge clk);
    rst_ni = 1;
    step(1'b1, 8'h02, "R5 post-reset add", "R3 post-reset sub");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end
endmodule